// File: doc/BRIEF.md
# Programmable Output Data Rate Divider

This block produces a periodic data-ready pulse by counting cycles of the master clock and restarting once a programmable number of cycles has elapsed. The length of each period is derived from a 16-bit control word that holds a 3-bit coarse select and an 11-bit fine adjustment. The coarse select picks a power-of-two multiple of a base count of 384. The fine field is scaled by a fixed-point constant whose fractional part is discarded. The two terms are added, and the result is raised to a floor of two cycles.

Software writes the control word through a simple strobe-and-data port and can read it back at any time. The written word only sits in a holding register. The period counter takes the new length at the end of the period that is running, so the pulse train never shows a shortened or stretched period. It changes length within one period of the write.

Top module: `odr_rate_divider`

## Requirements
- R1: The period in master-clock cycles equals (2^coarse) × 384 plus the fine term, where coarse is control bits [13:11] and fine is control bits [10:0].
- R2: The fine term is floor(fine × 24 / 16), which is fine × 1.5 with any fraction dropped. A fine value of 1 adds 1 cycle and a value of 3 adds 4.
- R3: Read-back returns the last written word with bits [15:14] forced to zero, and it holds while no write occurs.
- R4: The data-ready output is high for exactly one cycle per period. The cycle after that pulse begins a new count from zero.
- R5: A write made in the middle of a period leaves the length of that period unchanged. The next full period uses the new setting.
- R6: When the computed length is below 2, the period is 2 cycles.
- R7: After synchronous reset, the control word reads 0 and data-ready is low. The first pulse comes on the 384th cycle after reset is released, and the periods that follow are 384 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word to be written |
| rd_data_o | output | 16 | Control word read-back |
| drdy_o | output | 1 | One-cycle data-ready pulse at the end of each period |

## Verification
The assertions assume that reset is held for at least one clock edge before any checked behaviour begins. They also assume that the parameters give a length that fits the counter width, which means the largest coarse multiple plus the largest fine term stays below 2^17. The bench drives writes only between clock edges and reads the outputs at the falling edge. It measures periods only on settings short enough that two full periods fit well inside the run. A second instance with a zero base count makes the minimum-length floor reachable, and sweeping the fine field on that instance covers both the floor and the truncation.

// File: rtl/odr_pkg.sv
package odr_pkg;

  // Coarse multiplier: a power of two selected by the coarse field.
  function automatic int unsigned coarse_mult(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // Fine contribution: fixed-point product with the fraction dropped.
  function automatic int unsigned fine_term(input int unsigned fine,
                                            input int unsigned fine_q,
                                            input int unsigned frac_bits);
    return (fine * fine_q) >> frac_bits;
  endfunction

  // Full period length including the lower floor.
  function automatic int unsigned period_len(input int unsigned sel,
                                             input int unsigned fine,
                                             input int unsigned base,
                                             input int unsigned fine_q,
                                             input int unsigned frac_bits,
                                             input int unsigned min_len);
    int unsigned raw;
    raw = coarse_mult(sel) * base + fine_term(fine, fine_q, frac_bits);
    return (raw < min_len) ? min_len : raw;
  endfunction

endpackage

// File: rtl/odr_ctrl_reg.sv
module odr_ctrl_reg #(
  parameter int CTRL_W   = 16,
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 11
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic [CTRL_W-1:0]   wr_data_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o
);

  localparam int USED_W = COARSE_W + FINE_W;
  localparam logic [CTRL_W-1:0] USED_MASK = CTRL_W'((64'd1 << USED_W) - 64'd1);

  logic [CTRL_W-1:0] hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q <= '0;
    end else if (wr_en_i) begin
      hold_q <= wr_data_i & USED_MASK;
    end
  end

  assign ctrl_o   = hold_q;
  assign coarse_o = hold_q[FINE_W +: COARSE_W];
  assign fine_o   = hold_q[FINE_W-1:0];

  // R3: the held word only moves on a write.
  a_r3_hold_without_write: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |=> $stable(ctrl_o));

endmodule

// File: rtl/odr_len_calc.sv
module odr_len_calc #(
  parameter int COARSE_W  = 3,
  parameter int FINE_W    = 11,
  parameter int BASE_MULT = 384,
  parameter int FINE_Q    = 24,
  parameter int FRAC_BITS = 4,
  parameter int MIN_LEN   = 2,
  parameter int LEN_W     = 17
) (
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic [LEN_W-1:0]    len_o
);

  localparam int NUM_SEL = 1 << COARSE_W;
  localparam int PROD_W  = FINE_W + 16;

  logic [LEN_W-1:0]  coarse_tab [NUM_SEL];
  logic [PROD_W-1:0] fine_prod;
  logic [LEN_W-1:0]  fine_part;
  logic [LEN_W-1:0]  raw_len;

  // Coarse lookup, one entry per select value, computed from the index.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_coarse
    assign coarse_tab[g] = LEN_W'(odr_pkg::coarse_mult(g) * BASE_MULT);
  end

  // Full-precision product, then the fractional bits fall away.
  assign fine_prod = PROD_W'(fine_i) * PROD_W'(FINE_Q);
  assign fine_part = LEN_W'(fine_prod >> FRAC_BITS);
  assign raw_len   = coarse_tab[coarse_i] + fine_part;

  always_comb begin
    if (raw_len < LEN_W'(MIN_LEN)) begin
      len_o = LEN_W'(MIN_LEN);
    end else begin
      len_o = raw_len;
    end
  end

endmodule

// File: rtl/odr_period_counter.sv
module odr_period_counter #(
  parameter int LEN_W     = 17,
  parameter int MIN_LEN   = 2,
  parameter int RESET_LEN = 384
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [LEN_W-1:0] next_len_i,
  output logic             wrap_o,
  output logic             drdy_o
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] active_q;
  logic             wrap_evt;

  assign wrap_evt = (cnt_q == active_q - LEN_W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      active_q <= LEN_W'(RESET_LEN);
    end else if (wrap_evt) begin
      cnt_q    <= '0;
      active_q <= next_len_i;
    end else begin
      cnt_q    <= cnt_q + LEN_W'(1);
    end
  end

  assign wrap_o = wrap_evt;
  assign drdy_o = wrap_evt;

  // R4: the pulse never lasts two cycles.
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    drdy_o |=> !drdy_o);

  // R4: the count restarts at zero after the pulse.
  a_r4_restart_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> (cnt_q == '0));

  // R4: the count stays inside the active period.
  a_r4_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < active_q);

  // R5: the active length changes only at a wrap.
  a_r5_hold_mid_period: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_o |=> $stable(active_q));

  // R6: the active length never drops below the floor.
  a_r6_floor: assert property (@(posedge clk_i) disable iff (rst_i)
    active_q >= LEN_W'(MIN_LEN));

endmodule

// File: rtl/odr_rate_divider.sv
module odr_rate_divider #(
  parameter int CTRL_W    = 16,
  parameter int COARSE_W  = 3,
  parameter int FINE_W    = 11,
  parameter int BASE_MULT = 384,
  parameter int FINE_Q    = 24,
  parameter int FRAC_BITS = 4,
  parameter int MIN_LEN   = 2,
  parameter int LEN_W     = 17
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              drdy_o
);

  localparam int RESET_LEN = int'(odr_pkg::period_len(0, 0, BASE_MULT, FINE_Q,
                                                      FRAC_BITS, MIN_LEN));

  logic [COARSE_W-1:0] coarse_sel;
  logic [FINE_W-1:0]   fine_sel;
  logic [LEN_W-1:0]    next_len;
  logic                wrap_evt;

  odr_ctrl_reg #(
    .CTRL_W   (CTRL_W),
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (rd_data_o),
    .coarse_o  (coarse_sel),
    .fine_o    (fine_sel)
  );

  odr_len_calc #(
    .COARSE_W  (COARSE_W),
    .FINE_W    (FINE_W),
    .BASE_MULT (BASE_MULT),
    .FINE_Q    (FINE_Q),
    .FRAC_BITS (FRAC_BITS),
    .MIN_LEN   (MIN_LEN),
    .LEN_W     (LEN_W)
  ) u_calc (
    .coarse_i (coarse_sel),
    .fine_i   (fine_sel),
    .len_o    (next_len)
  );

  odr_period_counter #(
    .LEN_W     (LEN_W),
    .MIN_LEN   (MIN_LEN),
    .RESET_LEN (RESET_LEN)
  ) u_count (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .next_len_i (next_len),
    .wrap_o     (wrap_evt),
    .drdy_o     (drdy_o)
  );

  // R6: the computed next length respects the floor.
  a_r6_next_floor: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_evt |-> (next_len >= LEN_W'(MIN_LEN)));

endmodule

// File: tb/odr_rate_divider_tb.sv
module odr_rate_divider_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [15:0] wd_a = '0, wd_b = '0;
  logic [15:0] rd_a, rd_b;
  logic        drdy_a, drdy_b;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  odr_rate_divider u_dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_a), .wr_data_i(wd_a),
    .rd_data_o(rd_a), .drdy_o(drdy_a)
  );

  // Zero base count so that the two-cycle floor is reachable.
  odr_rate_divider #(.BASE_MULT(0)) u_dut_zero (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_b), .wr_data_i(wd_b),
    .rd_data_o(rd_b), .drdy_o(drdy_b)
  );

  function automatic int expect_len(int base, int sel, int fine);
    int v;
    v = base * (1 << sel) + ((fine * 3) >> 1);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pulse(int which);
    return (which == 0) ? drdy_a : drdy_b;
  endfunction

  task automatic write_reg(int which, logic [15:0] v);
    @(negedge clk);
    if (which == 0) begin wr_a = 1'b1; wd_a = v; end
    else            begin wr_b = 1'b1; wd_b = v; end
    @(negedge clk);
    wr_a = 1'b0;
    wr_b = 1'b0;
  endtask

  task automatic wait_pulse(int which);
    int guard = 0;
    @(negedge clk);
    while (!pulse(which) && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Period from one pulse to the next; also checks the pulse width (R4).
  task automatic measure(int which, output int per);
    int k = 0;
    wait_pulse(which);
    do begin
      @(negedge clk);
      k++;
      if (k == 1) check(!pulse(which), "R4 pulse width", int'(pulse(which)), 0);
    end while (!pulse(which) && k < 70000);
    per = k;
  endtask

  task automatic run_len(int which, int base, int sel, int fine, string req);
    int per;
    write_reg(which, 16'((sel << 11) | fine));
    measure(which, per);
    check(per == expect_len(base, sel, fine), req, per, expect_len(base, sel, fine));
  endtask

  initial begin
    #(190000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per;
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R7: reset state at the release cycle.
    check(rd_a == 16'h0000, "R7 readback after reset", int'(rd_a), 0);
    check(drdy_a == 1'b0, "R7 drdy after reset", int'(drdy_a), 0);
    check(rd_b == 16'h0000, "R7 readback after reset (zero base)", int'(rd_b), 0);
    k = 0;
    while (!drdy_a && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check(k == 383, "R7 first pulse offset", k, 383);
    measure(0, per);
    check(per == 384, "R7 reset period", per, 384);
    measure(1, per);
    check(per == 2, "R6 reset floor", per, 2);

    // R1 and R2: sweep of settings on the default instance.
    run_len(0, 384, 0, 1, "R2 fine=1");
    run_len(0, 384, 0, 2, "R2 fine=2");
    run_len(0, 384, 0, 3, "R2 fine=3");
    run_len(0, 384, 0, 100, "R1 fine=100");
    run_len(0, 384, 0, 2047, "R1 fine max");
    run_len(0, 384, 1, 0, "R1 coarse=1");
    run_len(0, 384, 2, 5, "R1 coarse=2 fine=5");
    run_len(0, 384, 3, 0, "R1 coarse=3");
    run_len(0, 384, 4, 7, "R1 coarse=4 fine=7");

    // R6 and R2: exhaustive low fine range with a zero base count.
    for (int f = 0; f < 32; f++) begin
      run_len(1, 0, 0, f, "R6 zero-base sweep");
    end

    // R3: unused bits read as zero, other bits kept.
    write_reg(0, 16'hC005);
    check(rd_a == 16'h0005, "R3 readback mask", int'(rd_a), 5);
    repeat (5) @(negedge clk);
    check(rd_a == 16'h0005, "R3 readback hold", int'(rd_a), 5);
    write_reg(0, 16'h8803);
    check(rd_a == 16'h0803, "R3 readback mask 2", int'(rd_a), 16'h0803);
    measure(0, per);
    check(per == expect_len(384, 1, 3), "R1 from masked write", per, expect_len(384, 1, 3));

    // R5: write mid period.
    write_reg(0, 16'h0000);
    measure(0, per);
    check(per == 384, "R5 settle", per, 384);
    wait_pulse(0);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 100) begin wr_a = 1'b1; wd_a = 16'd100; end
      if (k == 101) wr_a = 1'b0;
    end while (!drdy_a && k < 70000);
    check(k == 384, "R5 running period kept", k, 384);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!drdy_a && k < 70000);
    check(k == 534, "R5 next period new", k, 534);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule